// File: doc/BRIEF.md
# BFloat16 Fused Multiply-Subtract Lane

This block is a pipelined arithmetic lane for 16-bit BFloat16 numbers. Each accepted request carries three operands: a multiplicand, a multiplier and an addend. It returns `addend - multiplicand * multiplier`. The result is the value that the addend's element is overwritten with. The subtraction is formed by inverting the sign of the multiplicand before a fused multiply-add. The addend keeps its own sign. The exact product is summed with the addend, and rounding happens once, at the end.

A two-bit control travels with each request. One bit flushes subnormal inputs and subnormal results to zero. The other bit replaces every NaN result with the default NaN. Each result comes out with four exception flags. Requests enter and results leave through valid/ready handshakes. When the output is stalled, the whole pipeline stalls with it.

Top module: `bf16_fms`

## Requirements
- R1: Operands and result use the 1/8/7 sign/exponent/fraction BFloat16 layout. The finite result is `addend + (-mcand * mplier)`, computed exactly and rounded once to nearest-even at 8 significant bits.
- R2: Only the multiplicand's sign is inverted, never the addend's. A NaN that is propagated from the multiplicand therefore comes out with its sign bit inverted.
- R3: A zero sum from operands of opposite sign is +0. The sum of two zeros of the same sign keeps that sign.
- R4: If the rounded magnitude exceeds the largest finite value, the result is an infinity of the correct sign, and the overflow and inexact flags are set.
- R5: When flush is clear, subnormal inputs and subnormal results are exact (exponent field 0, value = fraction × 2^-133). The underflow flag is set only together with inexact, for a rounded result whose exponent field is 0.
- R6: When flush is set, subnormal inputs act as zeros of their own sign. A result whose exponent field would be 0 becomes a zero of its own sign, with underflow and inexact set.
- R7: Infinity times zero, and an infinite product added to an infinite addend of the opposite sign, set invalid and return 0x7FC0 when no input is a NaN.
- R8: A signalling NaN input (exponent all ones, fraction bit 6 clear, fraction nonzero) sets invalid. When the default-NaN bit is clear, the NaN result is taken from the addend first, then from the sign-inverted multiplicand, then from the multiplier, with fraction bit 6 set. When the default-NaN bit is set, every NaN result is 0x7FC0.
- R9: Infinite results that do not come from an invalid case are exact and raise no flag.
- R10: The flag vector is bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R11: The handshake edge of a result comes three clock edges after the edge that accepted its request, provided the output is never stalled. With the output never stalled, a new request is accepted on every cycle.
- R12: After reset, out_valid is 0 and in_ready is 1. While out_valid is 1 and out_ready is 0, in_ready is 0 and the result and flags hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_mcand | input | 16 | Multiplicand (its sign is inverted) |
| in_mplier | input | 16 | Multiplier |
| in_addend | input | 16 | Addend and destination element |
| in_ftz | input | 1 | Flush subnormal inputs and results to zero |
| in_dnan | input | 1 | Return the default NaN for every NaN result |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_res | output | 16 | Result |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
A result is due on the third rising edge after the edge that accepted its request, as long as out_ready stays high. Stalls push that edge back by one for each stalled cycle. The bench records each request at mid-cycle, before the edge that accepts it. It matches each result in order at mid-cycle, before the edge that takes it, so no check races an edge. Latency is checked only in phases where out_ready is held high and the pipeline has drained before the phase starts. During stalls, a held result is compared with its value on the cycle before.

// File: rtl/bf16_fms.sv
`timescale 1ns/1ps
module bf16_fms (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_mcand,
  input  logic [15:0] in_mplier,
  input  logic [15:0] in_addend,
  input  logic        in_ftz,
  input  logic        in_dnan,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_res,
  output logic [3:0]  out_flags
);
  localparam int ALIGN = 32;
  localparam int FW = 2 * ALIGN + 17;

  function automatic logic f_nan(input logic [15:0] x);
    return x[14:7] == 8'hFF && x[6:0] != 7'd0;
  endfunction
  function automatic logic f_inf(input logic [15:0] x);
    return x[14:7] == 8'hFF && x[6:0] == 7'd0;
  endfunction
  function automatic logic f_zero(input logic [15:0] x, input logic ftz);
    return x[14:7] == 8'h00 && (ftz || x[6:0] == 7'd0);
  endfunction
  function automatic logic [7:0] f_sig(input logic [15:0] x, input logic ftz);
    return (x[14:7] == 8'h00) ? (ftz ? 8'd0 : {1'b0, x[6:0]}) : {1'b1, x[6:0]};
  endfunction
  function automatic logic signed [9:0] f_exp(input logic [15:0] x);
    return (x[14:7] == 8'h00) ? -10'sd126 : $signed({2'b00, x[14:7]}) - 10'sd127;
  endfunction

  logic adv;
  assign adv = !out_valid || out_ready;
  assign in_ready = adv;

  wire [15:0] a = in_mcand, b = in_mplier, c = in_addend;
  wire [15:0] an = {~a[15], a[14:0]};
  wire sp = ~a[15] ^ b[15];

  logic spec, sinv;
  logic [15:0] sres;
  always_comb begin
    spec = 1'b1; sinv = 1'b0; sres = 16'h7FC0;
    if (f_nan(a) || f_nan(b) || f_nan(c)) begin
      sinv = (f_nan(a) && !a[6]) || (f_nan(b) && !b[6]) || (f_nan(c) && !c[6]);
      if (!in_dnan)
        sres = f_nan(c) ? (c | 16'h0040) : f_nan(an) ? (an | 16'h0040) : (b | 16'h0040);
    end else if ((f_inf(a) && f_zero(b, in_ftz)) || (f_zero(a, in_ftz) && f_inf(b)))
      sinv = 1'b1;
    else if (f_inf(a) || f_inf(b)) begin
      if (f_inf(c) && c[15] != sp) sinv = 1'b1;
      else sres = {sp, 8'hFF, 7'd0};
    end else if (f_inf(c)) sres = c;
    else spec = 1'b0;
  end

  logic s1_v, s1_spec, s1_sinv, s1_sp, s1_sc, s1_ftz;
  logic [15:0] s1_sres, s1_pm, s1_cm;
  logic signed [9:0] s1_pe, s1_ce;
  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else if (adv) s1_v <= in_valid;
    if (adv) begin
      s1_spec <= spec; s1_sinv <= sinv; s1_sres <= sres; s1_ftz <= in_ftz;
      s1_sp <= sp; s1_sc <= c[15];
      s1_pm <= f_sig(a, in_ftz) * f_sig(b, in_ftz);
      s1_pe <= f_exp(a) + f_exp(b) - 10'sd14;
      s1_cm <= {f_sig(c, in_ftz), 8'd0};
      s1_ce <= f_exp(c) - 10'sd15;
    end
  end

  logic [48:0] sum;
  logic sum_sg;
  logic signed [10:0] sum_eb;
  always_comb begin
    logic pick_p, sx, sy;
    logic [15:0] xm, ym;
    int ex, d;
    logic [47:0] fx, fy;
    logic [95:0] yw;
    pick_p = (s1_cm == 16'd0) || (s1_pm != 16'd0 && s1_pe >= s1_ce);
    xm = pick_p ? s1_pm : s1_cm;
    ym = pick_p ? s1_cm : s1_pm;
    sx = pick_p ? s1_sp : s1_sc;
    sy = pick_p ? s1_sc : s1_sp;
    ex = pick_p ? int'(s1_pe) : int'(s1_ce);
    d  = pick_p ? int'(s1_pe) - int'(s1_ce) : int'(s1_ce) - int'(s1_pe);
    if (d > 63) d = 63;
    fx = {xm, 32'd0};
    yw = {ym, 32'd0, 48'd0} >> d;
    fy = yw[95:48] | {47'd0, |yw[47:0]};
    if (sx == sy) begin sum = {1'b0, fx} + {1'b0, fy}; sum_sg = sx; end
    else if (fx >= fy) begin sum = {1'b0, fx - fy}; sum_sg = sx; end
    else begin sum = {1'b0, fy - fx}; sum_sg = sy; end
    sum_eb = 11'(ex - ALIGN);
  end

  logic s2_v, s2_spec, s2_sinv, s2_sg, s2_zs, s2_ftz;
  logic [15:0] s2_sres;
  logic [48:0] s2_f;
  logic signed [10:0] s2_eb;
  always_ff @(posedge clk) begin
    if (!rst_n) s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
    if (adv) begin
      s2_spec <= s1_spec; s2_sinv <= s1_sinv; s2_sres <= s1_sres; s2_ftz <= s1_ftz;
      s2_f <= sum; s2_sg <= sum_sg; s2_eb <= sum_eb; s2_zs <= s1_sp & s1_sc;
    end
  end

  logic [15:0] res;
  logic [3:0] flg;
  always_comb begin
    int k, eb, lsbe, r, expf;
    logic [63:0] f64;
    logic [8:0] q;
    logic g, st, ix;
    k = 0;
    for (int i = 0; i < 49; i++) if (s2_f[i]) k = i;
    eb = int'(s2_eb);
    lsbe = (eb + k - 7 < -133) ? -133 : eb + k - 7;
    r = lsbe - eb;
    f64 = {15'd0, s2_f};
    g = 1'b0; st = 1'b0;
    if (r <= 0) q = 9'(f64 << (-r));
    else begin
      if (r > 63) r = 63;
      q  = 9'(f64 >> r);
      g  = f64[r-1];
      st = |(f64 & ((64'd1 << (r-1)) - 64'd1));
    end
    ix = g | st;
    q = q + {8'd0, g & (st | q[0])};
    if (q[8]) begin q = 9'd128; lsbe = lsbe + 1; end
    expf = q[7] ? lsbe + 134 : 0;
    if (s2_spec) begin res = s2_sres; flg = {s2_sinv, 3'b000}; end
    else if (s2_f == 49'd0) begin res = {s2_zs, 15'd0}; flg = 4'b0000; end
    else if (expf >= 255) begin res = {s2_sg, 8'hFF, 7'd0}; flg = 4'b0101; end
    else if (expf == 0) begin
      if (s2_ftz) begin res = {s2_sg, 15'd0}; flg = 4'b0011; end
      else begin res = {s2_sg, 8'd0, q[6:0]}; flg = {2'b00, ix, ix}; end
    end else begin res = {s2_sg, 8'(expf), q[6:0]}; flg = {3'b000, ix}; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= s2_v;
    if (adv) begin out_res <= res; out_flags <= flg; end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_flags)); // R12
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res[14:7] == 8'hFF && out_res[6:0] != 7'd0 |-> out_res[6]); // R8
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[2] |-> out_res[14:0] == 15'h7F80); // R4
  AST_INV_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[3] |-> out_res[14:7] == 8'hFF && out_res[6:0] != 7'd0); // R7
  AST_UF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[1] |-> out_flags[0] && out_res[14:7] == 8'h00); // R5
endmodule

// File: tb/sim_bf16_fms.sv
`timescale 1ns/1ps
module sim_bf16_fms;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_ftz = 1'b0, in_dnan = 1'b0;
  logic [15:0] in_mcand = '0, in_mplier = '0, in_addend = '0;
  logic out_valid, out_ready = 1'b1;
  logic [15:0] out_res;
  logic [3:0] out_flags;
  int checks = 0, errors = 0, cyc = 0, rmode = 0;
  string cur_tag = "";
  logic [19:0] q_exp[$];
  string q_tag[$];
  int q_t[$];
  logic prev_stall = 1'b0;
  logic [15:0] prev_res;
  logic [3:0] prev_flg;

  bf16_fms u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcand(in_mcand), .in_mplier(in_mplier), .in_addend(in_addend), .in_ftz(in_ftz),
    .in_dnan(in_dnan), .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_flags(out_flags));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit is_nan(logic [15:0] x); return x[14:7] == 8'hFF && x[6:0] != 0; endfunction
  function automatic bit is_inf(logic [15:0] x); return x[14:7] == 8'hFF && x[6:0] == 0; endfunction
  function automatic bit is_zero(logic [15:0] x, bit f); return x[14:7] == 0 && (f || x[6:0] == 0); endfunction
  function automatic real p2(int n); return $bitstoreal({1'b0, 11'(n + 1023), 52'd0}); endfunction
  function automatic real val(logic [15:0] x, bit f);
    real m;
    if (x[14:7] == 0) m = f ? 0.0 : real'(int'(x[6:0])) * p2(-133);
    else m = real'(128 + int'(x[6:0])) * p2(int'(x[14:7]) - 134);
    return x[15] ? -m : m;
  endfunction

  function automatic logic [19:0] round16(real s, real e, bit f, output string tag);
    logic [63:0] bits, m;
    logic sg, g, rest, esame, ix;
    int ee, lsb, r, expf;
    logic [8:0] q;
    bits = $realtobits(s);
    sg = bits[63];
    if (s == 0.0) begin tag = "R3"; return {4'b0000, sg, 15'd0}; end
    ee = int'(bits[62:52]) - 1023;
    m = {11'd0, 1'b1, bits[51:0]};
    lsb = (ee - 7 < -133) ? -133 : ee - 7;
    r = lsb - (ee - 52);
    if (r > 63) r = 63;
    q = 9'(m >> r);
    g = m[r-1];
    rest = (m & ((64'd1 << (r-1)) - 64'd1)) != 0;
    esame = (e != 0.0) && ((e > 0.0) == (s > 0.0));
    ix = g || rest || (e != 0.0);
    if (g && (rest || esame || (e == 0.0 && q[0]))) q = q + 9'd1;
    if (q == 9'd256) begin q = 9'd128; lsb++; end
    expf = q[7] ? lsb + 134 : 0;
    if (expf >= 255) begin tag = "R4"; return {4'b0101, sg, 8'hFF, 7'd0}; end
    if (expf == 0) begin
      if (f) begin tag = "R6"; return {4'b0011, sg, 15'd0}; end
      tag = "R5"; return {2'b00, ix, ix, sg, 8'd0, q[6:0]};
    end
    tag = "R1";
    return {3'b000, ix, sg, 8'(expf), q[6:0]};
  endfunction

  function automatic logic [19:0] model(logic [15:0] a, b, c, bit f, bit dn, output string tag);
    logic [15:0] na;
    bit ps, inv;
    real va, vb, vc, p, s, bb, e;
    na = a ^ 16'h8000;
    ps = na[15] ^ b[15];
    if (is_nan(a) || is_nan(b) || is_nan(c)) begin
      tag = "R8";
      inv = (is_nan(a) && !a[6]) || (is_nan(b) && !b[6]) || (is_nan(c) && !c[6]);
      if (dn) return {inv, 3'b000, 16'h7FC0};
      if (is_nan(c)) return {inv, 3'b000, c | 16'h0040};
      if (is_nan(a)) return {inv, 3'b000, na | 16'h0040};
      return {inv, 3'b000, b | 16'h0040};
    end
    if ((is_inf(a) && is_zero(b, f)) || (is_inf(b) && is_zero(a, f))) begin
      tag = "R7"; return {4'b1000, 16'h7FC0};
    end
    if (is_inf(a) || is_inf(b)) begin
      if (is_inf(c) && c[15] != ps) begin tag = "R7"; return {4'b1000, 16'h7FC0}; end
      tag = "R9"; return {4'b0000, ps, 15'h7F80};
    end
    if (is_inf(c)) begin tag = "R9"; return {4'b0000, c}; end
    va = val(a, f); vb = val(b, f); vc = val(c, f);
    p = -(va * vb);
    s = vc + p;
    bb = s - vc;
    e = (vc - (s - bb)) + (p - bb);
    return round16(s, e, f, tag);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      if (cyc == 3) begin
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          errors++; $display("FAIL R12 reset got v=%b r=%b exp v=0 r=1", out_valid, in_ready);
        end
      end
    end else begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_res !== prev_res || out_flags !== prev_flg) begin
          errors++; $display("FAIL R12 hold got %h/%b exp %h/%b", out_res, out_flags, prev_res, prev_flg);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin errors++; $display("FAIL R12 in_ready got 1 exp 0"); end
      end
      if (rmode == 0 && in_valid) begin
        checks++;
        if (!in_ready) begin errors++; $display("FAIL R11 throughput in_ready got 0 exp 1"); end
      end
      prev_stall = out_valid && !out_ready;
      prev_res = out_res; prev_flg = out_flags;
      if (in_valid && in_ready) begin
        string t;
        logic [19:0] x;
        x = model(in_mcand, in_mplier, in_addend, in_ftz, in_dnan, t);
        q_exp.push_back(x);
        q_tag.push_back(cur_tag != "" ? cur_tag : t);
        q_t.push_back(cyc + 1);
      end
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          checks++; errors++; $display("FAIL R11 unexpected result got %h exp none", out_res);
        end else begin
          logic [19:0] x;
          string t;
          int t0;
          x = q_exp.pop_front(); t = q_tag.pop_front(); t0 = q_t.pop_front();
          checks++;
          if (out_res !== x[15:0]) begin
            errors++; $display("FAIL %s result got %h exp %h", t, out_res, x[15:0]);
          end
          checks++;
          if (out_flags !== x[19:16]) begin
            errors++; $display("FAIL R10 (%s) flags got %b exp %b", t, out_flags, x[19:16]);
          end
          if (rmode == 0) begin
            checks++;
            if (cyc + 1 - t0 != 3) begin
              errors++; $display("FAIL R11 latency got %0d exp 3", cyc + 1 - t0);
            end
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rmode == 1) out_ready <= ($urandom % 10) < 6;
    else out_ready <= 1'b1;
  end

  task automatic send(input logic [15:0] a, b, c, input bit f, input bit dn, input string t);
    bit acc;
    in_mcand = a; in_mplier = b; in_addend = c; in_ftz = f; in_dnan = dn; cur_tag = t;
    in_valid = 1'b1;
    forever begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    in_valid = 1'b0; cur_tag = "";
  endtask

  function automatic logic [15:0] pick_special();
    case ($urandom % 11)
      0: return 16'h0000; 1: return 16'h8000; 2: return 16'h7F80; 3: return 16'hFF80;
      4: return 16'h7FC0; 5: return 16'h7F81; 6: return 16'h0001; 7: return 16'h807F;
      8: return 16'h0080; 9: return 16'h7F7F; default: return 16'h3F80;
    endcase
  endfunction

  task automatic send_random(input bit gaps);
    logic [15:0] a, b, c;
    int kind, ea, eb, ec;
    kind = $urandom % 10;
    a = 16'($urandom); b = 16'($urandom); c = 16'($urandom);
    if (kind >= 4 && kind <= 7) begin
      ea = 110 + $urandom % 35; eb = 110 + $urandom % 35;
      ec = ea + eb - 127 + int'($urandom % 21) - 10;
      if (ec < 1) ec = 1;
      if (ec > 254) ec = 254;
      a[14:7] = 8'(ea); b[14:7] = 8'(eb); c[14:7] = 8'(ec);
    end else if (kind == 8) begin
      a[14:7] = 8'($urandom % 11); b[14:7] = 8'(120 + $urandom % 10); c[14:7] = 8'($urandom % 4);
    end else if (kind == 9) begin
      a = pick_special(); b = pick_special(); c = pick_special();
    end
    send(a, b, c, ($urandom % 4) == 0, ($urandom % 4) == 0, "");
    if (gaps) repeat ($urandom % 3) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q_exp.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    send(16'h3F80, 16'h3F80, 16'h3F80, 0, 0, "R3");
    send(16'h0000, 16'h3F80, 16'h8000, 0, 0, "R3");
    send(16'h3F80, 16'h4000, 16'h0000, 0, 0, "R2");
    send(16'hBF80, 16'h4000, 16'h0000, 0, 0, "R2");
    send(16'h3F80, 16'h3F80, 16'hC000, 0, 0, "R2");
    send(16'h3F81, 16'h3F81, 16'h0000, 0, 0, "R1");
    send(16'h3F80, 16'h3B80, 16'h4380, 0, 0, "R1");
    send(16'h7F7F, 16'h7F7F, 16'h0000, 0, 0, "R4");
    send(16'hFF7F, 16'h7F7F, 16'h7F7F, 0, 0, "R4");
    send(16'h0001, 16'h3F80, 16'h0000, 0, 0, "R5");
    send(16'h0080, 16'h3F00, 16'h0000, 0, 0, "R5");
    send(16'h0081, 16'h3E80, 16'h0000, 0, 0, "R5");
    send(16'h0001, 16'h3F80, 16'h0000, 1, 0, "R6");
    send(16'h0080, 16'h3F00, 16'h0000, 1, 0, "R6");
    send(16'h3F80, 16'h3F80, 16'h8005, 1, 0, "R6");
    send(16'h7F80, 16'h0000, 16'h3F80, 0, 0, "R7");
    send(16'h0001, 16'hFF80, 16'h3F80, 1, 0, "R7");
    send(16'h7F80, 16'h3F80, 16'h7F80, 0, 0, "R7");
    send(16'h7F80, 16'h3F80, 16'hFF80, 0, 0, "R9");
    send(16'h3F80, 16'h3F80, 16'hFF80, 0, 0, "R9");
    send(16'h3F80, 16'h7F81, 16'h3F80, 0, 0, "R8");
    send(16'h3F80, 16'h7F81, 16'h3F80, 0, 1, "R8");
    send(16'h7FC5, 16'h3F80, 16'h7FC3, 0, 0, "R8");
    send(16'h7FA0, 16'h3F80, 16'h4000, 0, 0, "R2");
    send(16'h3F80, 16'hFFC1, 16'h7F80, 0, 0, "R8");
    drain();
    repeat (2000) send_random(0);
    drain();
    rmode = 1;
    repeat (2000) send_random(1);
    drain();
    rmode = 0;
    repeat (500) send_random(0);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule